// File: doc/BRIEF.md
# Receive-Side Scaling Hash and Channel Selector

This block sits in a receive path after the header parser. For each IPv4 packet it accepts a parsed descriptor: the two addresses, the two transport ports and a packet-type code. It decides from a small control word whether the packet is hashed. If it is, it runs a Toeplitz hash over the selected fields with a 40-byte secret key. The low seven bits of the 32-bit result pick one of 128 lookup-table entries, and that entry names the DMA channel that receives the packet.

The key and the table are held outside the block and reach it as flat vectors, because loading them is another block's job. Each packet produces one result with a one-cycle done pulse: the hash, a hash-valid flag, the hash class for the receive descriptor, the chosen channel and a drop flag. The drop flag is set when the table entry is not valid. The hash is computed one input bit per clock, which keeps the logic to a single 32-bit XOR stage.

Top module: `rss_steer`

## Requirements
- R1: During and right after reset, done_o, busy_o, hash_valid_o and drop_o are 0, and hash_o, hash_class_o and chan_o are all zero.
- R2: ctrl_i bit 0 is the global enable. With bit 0 set, a TCP packet (ptype_i=2) with ctrl_i bit 2 set, or a UDP packet (ptype_i=3) with ctrl_i bit 3 set, is hashed over 96 bits. The bits are taken most significant bit first, in this order: source address, destination address, source port, destination port. For each input bit i (0-based) that is 1, the 32 key bits key_i[319-i -: 32] are XORed into the hash, so key byte 0 sits in key_i[319:312].
- R3: An IP-only packet (ptype_i=1) is hashed over the 64 address bits only, in the same order, when ctrl_i bits 0 and 1 are both set.
- R4: A TCP or UDP packet whose own enable bit is clear, but with ctrl_i bits 0 and 1 set, is hashed over the addresses only, as in R3, and is reported with class 2.
- R5: A packet that is not hashed gives hash_valid_o=0, hash_o=0, hash_class_o=0, drop_o=0 and chan_o equal to dflt_chan_i as sampled at start. This covers a clear global enable, a class that is not enabled, and ptype_i=0.
- R6: The table index is hash_o[6:0]. Entry n occupies lut_i[5n+4:5n], with bit 4 as the valid bit and bits 3:0 as the channel. A valid entry drives chan_o and leaves drop_o at 0.
- R7: A hashed packet whose table entry has its valid bit clear gives drop_o=1 and chan_o equal to the default channel, while hash_valid_o=1 and hash_o still carry the hash.
- R8: hash_class_o is 3 for a hashed packet using ports (L4) and 2 for an address-only hash (L3).
- R9: done_o is a one-cycle pulse. Counted in rising edges after the edge that samples start_i, it comes N+1 edges later for an N-bit hash (97 for 96 bits, 65 for 64 bits) and 1 edge later for an unhashed packet. All outputs hold their values between done pulses.
- R10: A start_i while busy_o is 1 is ignored: it changes neither the running result nor the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 4 | Enables: bit0 global, bit1 IP-only, bit2 TCP, bit3 UDP |
| key_i | input | 320 | Hash key, byte 0 in the top eight bits |
| lut_i | input | 640 | 128 table entries of 5 bits {valid, channel} |
| dflt_chan_i | input | 4 | Channel for unhashed or unmatched packets |
| start_i | input | 1 | Descriptor present on the inputs |
| ptype_i | input | 2 | 0 other, 1 IP-only, 2 TCP, 3 UDP |
| src_ip_i | input | 32 | Source IPv4 address |
| dst_ip_i | input | 32 | Destination IPv4 address |
| src_port_i | input | 16 | Source transport port |
| dst_port_i | input | 16 | Destination transport port |
| busy_o | output | 1 | A packet is in progress; start is ignored |
| done_o | output | 1 | One-cycle result strobe |
| hash_o | output | 32 | Hash value |
| hash_valid_o | output | 1 | Hash was computed |
| hash_class_o | output | 2 | 0 none, 2 L3, 3 L4 |
| chan_o | output | 4 | Selected DMA channel |
| drop_o | output | 1 | Table entry invalid; packet to be dropped |

## Verification
The cycle-by-cycle properties are checked continuously by assertions. These cover the single-cycle done strobe, the holding of results between strobes, and the absence of done while a new packet is in progress. They also cover the consistency between the valid flag, the class code, a zero hash and the drop flag. Only the bench's scenarios can show that the hash values are correct against a reference model and that enables fall back from L4 to address-only hashing. The same applies to the exact latency, the table indexing, the drop case with an invalid entry, and a second start arriving mid-hash having no effect.

// File: rtl/rss_pkg.sv
package rss_pkg;
    localparam int KEY_BYTES = 40;
    localparam int HASH_W    = 32;
    localparam int IN_BITS   = 96;
    localparam int ADDR_BITS = 64;

    typedef enum logic [1:0] {
        PT_OTHER = 2'd0,
        PT_IP    = 2'd1,
        PT_TCP   = 2'd2,
        PT_UDP   = 2'd3
    } ptype_e;

    typedef enum logic [1:0] {
        HC_NONE = 2'd0,
        HC_RSVD = 2'd1,
        HC_L3   = 2'd2,
        HC_L4   = 2'd3
    } hclass_e;

    // control word bit positions
    localparam int CB_GLOBAL = 0;
    localparam int CB_IP     = 1;
    localparam int CB_TCP    = 2;
    localparam int CB_UDP    = 3;

    typedef struct packed {
        logic          hashed;
        logic          use_ports;
        hclass_e       cls;
    } gate_t;

    function automatic gate_t decide(input logic [3:0] ctrl, input ptype_e pt);
        gate_t g;
        logic l4_on;
        logic ip_on;
        l4_on = ctrl[CB_GLOBAL] &&
                (((pt == PT_TCP) && ctrl[CB_TCP]) || ((pt == PT_UDP) && ctrl[CB_UDP]));
        ip_on = ctrl[CB_GLOBAL] && ctrl[CB_IP] && (pt != PT_OTHER);
        g.hashed    = l4_on || ip_on;
        g.use_ports = l4_on;
        g.cls       = l4_on ? HC_L4 : (ip_on ? HC_L3 : HC_NONE);
        return g;
    endfunction
endpackage

// File: rtl/rss_class_gate.sv
module rss_class_gate
    import rss_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [3:0]       ctrl_i,
    input  logic [1:0]       ptype_i,
    input  logic [31:0]      src_ip_i,
    input  logic [31:0]      dst_ip_i,
    input  logic [15:0]      src_port_i,
    input  logic [15:0]      dst_port_i,
    output logic             hashed_o,
    output hclass_e          cls_o,
    output logic [CNT_W-1:0] nbits_o,
    output logic [IN_BITS-1:0] data_o
);
    gate_t g;

    always_comb begin
        g        = decide(ctrl_i, ptype_e'(ptype_i));
        hashed_o = g.hashed;
        cls_o    = g.cls;
        if (g.use_ports) begin
            nbits_o = CNT_W'(IN_BITS);
            data_o  = {src_ip_i, dst_ip_i, src_port_i, dst_port_i};
        end else begin
            nbits_o = CNT_W'(ADDR_BITS);
            data_o  = {src_ip_i, dst_ip_i, 32'd0};
        end
    end
endmodule

// File: rtl/rss_toeplitz_core.sv
module rss_toeplitz_core #(
    parameter int KEY_BITS = 320,
    parameter int HASH_W   = 32,
    parameter int IN_BITS  = 96,
    parameter int CNT_W    = $clog2(IN_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [KEY_BITS-1:0] key_i,
    input  logic                load_i,
    input  logic [IN_BITS-1:0]  data_i,
    input  logic [CNT_W-1:0]    nbits_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [HASH_W-1:0]   hash_o
);
    localparam int KIDX_W = $clog2(KEY_BITS);

    logic [IN_BITS-1:0] data_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   last_q;
    logic [HASH_W-1:0]  acc_q;
    logic [KIDX_W-1:0]  kidx;
    logic [HASH_W-1:0]  window;

    // key window slides one bit per consumed input bit
    always_comb begin
        kidx   = KIDX_W'(KEY_BITS - 1) - KIDX_W'(cnt_q);
        window = key_i[kidx -: HASH_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            cnt_q  <= '0;
            last_q <= '0;
            acc_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_i && !busy_o) begin
                data_q <= data_i;
                cnt_q  <= '0;
                last_q <= nbits_i - CNT_W'(1);
                acc_q  <= '0;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (data_q[IN_BITS-1]) acc_q <= acc_q ^ window;
                data_q <= data_q << 1;
                cnt_q  <= cnt_q + CNT_W'(1);
                if (cnt_q == last_q) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign hash_o = acc_q;
endmodule

// File: rtl/rss_chan_lookup.sv
module rss_chan_lookup #(
    parameter int DEPTH  = 128,
    parameter int CHAN_W = 4,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int ENT_W  = CHAN_W + 1
) (
    input  logic [DEPTH*ENT_W-1:0] lut_i,
    input  logic [IDX_W-1:0]       idx_i,
    output logic                   hit_o,
    output logic [CHAN_W-1:0]      chan_o
);
    logic [ENT_W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign ent[g] = lut_i[g*ENT_W +: ENT_W];
    end

    always_comb begin
        hit_o  = ent[idx_i][ENT_W-1];
        chan_o = ent[idx_i][CHAN_W-1:0];
    end
endmodule

// File: rtl/rss_steer.sv
module rss_steer
    import rss_pkg::*;
#(
    parameter int KEY_LEN   = KEY_BYTES,
    parameter int LUT_DEPTH = 128,
    parameter int CHAN_W    = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [3:0]                         ctrl_i,
    input  logic [KEY_LEN*8-1:0]               key_i,
    input  logic [LUT_DEPTH*(CHAN_W+1)-1:0]    lut_i,
    input  logic [CHAN_W-1:0]                  dflt_chan_i,
    input  logic                               start_i,
    input  logic [1:0]                         ptype_i,
    input  logic [31:0]                        src_ip_i,
    input  logic [31:0]                        dst_ip_i,
    input  logic [15:0]                        src_port_i,
    input  logic [15:0]                        dst_port_i,
    output logic                               busy_o,
    output logic                               done_o,
    output logic [HASH_W-1:0]                  hash_o,
    output logic                               hash_valid_o,
    output logic [1:0]                         hash_class_o,
    output logic [CHAN_W-1:0]                  chan_o,
    output logic                               drop_o
);
    localparam int KEY_BITS = KEY_LEN * 8;
    localparam int CNT_W    = $clog2(IN_BITS + 1);
    localparam int IDX_W    = $clog2(LUT_DEPTH);

    logic               g_hashed;
    hclass_e            g_cls;
    logic [CNT_W-1:0]   g_nbits;
    logic [IN_BITS-1:0] g_data;
    logic               accept;
    logic               eng_busy, eng_done;
    logic [HASH_W-1:0]  eng_hash;
    logic               lk_hit;
    logic [CHAN_W-1:0]  lk_chan;
    logic               byp_q;
    hclass_e            cls_q;
    logic [CHAN_W-1:0]  dflt_q;

    rss_class_gate #(.CNT_W(CNT_W)) u_gate (
        .ctrl_i(ctrl_i), .ptype_i(ptype_i),
        .src_ip_i(src_ip_i), .dst_ip_i(dst_ip_i),
        .src_port_i(src_port_i), .dst_port_i(dst_port_i),
        .hashed_o(g_hashed), .cls_o(g_cls), .nbits_o(g_nbits), .data_o(g_data)
    );

    assign busy_o = eng_busy | eng_done | byp_q;
    assign accept = start_i & ~busy_o;

    rss_toeplitz_core #(
        .KEY_BITS(KEY_BITS), .HASH_W(HASH_W), .IN_BITS(IN_BITS), .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst(rst), .key_i(key_i),
        .load_i(accept & g_hashed), .data_i(g_data), .nbits_i(g_nbits),
        .busy_o(eng_busy), .done_o(eng_done), .hash_o(eng_hash)
    );

    rss_chan_lookup #(.DEPTH(LUT_DEPTH), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_lookup (
        .lut_i(lut_i), .idx_i(eng_hash[IDX_W-1:0]),
        .hit_o(lk_hit), .chan_o(lk_chan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q  <= 1'b0;
            cls_q  <= HC_NONE;
            dflt_q <= '0;
        end else begin
            byp_q <= accept & ~g_hashed;
            if (accept) begin
                cls_q  <= g_cls;
                dflt_q <= dflt_chan_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o       <= 1'b0;
            hash_o       <= '0;
            hash_valid_o <= 1'b0;
            hash_class_o <= HC_NONE;
            chan_o       <= '0;
            drop_o       <= 1'b0;
        end else begin
            done_o <= eng_done | byp_q;
            if (eng_done) begin
                hash_o       <= eng_hash;
                hash_valid_o <= 1'b1;
                hash_class_o <= cls_q;
                chan_o       <= lk_hit ? lk_chan : dflt_q;
                drop_o       <= ~lk_hit;
            end else if (byp_q) begin
                hash_o       <= '0;
                hash_valid_o <= 1'b0;
                hash_class_o <= HC_NONE;
                chan_o       <= dflt_q;
                drop_o       <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rss_steer_chk.sv
module rss_steer_chk #(
    parameter int CHAN_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic [31:0]       hash_o,
    input logic              hash_valid_o,
    input logic [1:0]        hash_class_o,
    input logic [CHAN_W-1:0] chan_o,
    input logic              drop_o
);
    // R9: result strobe lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: outputs only move together with the strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(hash_o) && $stable(chan_o) && $stable(drop_o)
                     && $stable(hash_valid_o) && $stable(hash_class_o)));

    // R10: a strobe always follows a packet that was in progress
    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));

    // R7: drop only for a hashed packet
    p_drop_hashed_r7: assert property (@(posedge clk) disable iff (rst)
        drop_o |-> hash_valid_o);

    // R8: hashed packets carry class 2 or 3
    p_class_code_r8: assert property (@(posedge clk) disable iff (rst)
        hash_valid_o |-> (hash_class_o == 2'd2 || hash_class_o == 2'd3));

    // R5: unhashed packets report zero hash and no class
    p_unhashed_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !hash_valid_o |-> (hash_o == 32'd0 && hash_class_o == 2'd0 && !drop_o));
endmodule

bind rss_steer rss_steer_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o),
    .hash_o(hash_o), .hash_valid_o(hash_valid_o), .hash_class_o(hash_class_o),
    .chan_o(chan_o), .drop_o(drop_o)
);

// File: tb/sim_rss_steer.sv
module sim_rss_steer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 128;
    localparam logic [319:0] KEY =
        320'h6d5a56da255b0ec24167253d43a38fb0d0ca2bcbae7b30b477cb2da38030f20c6a42b73bbeac01fa;

    typedef struct packed {
        logic [3:0]  ctrl;
        logic [1:0]  pt;
        logic [31:0] sip;
        logic [31:0] dip;
        logic [15:0] sp;
        logic [15:0] dp;
        logic [3:0]  dflt;
        logic [6:0]  nbits;   // expected hashed bit count, 0 = unhashed
        logic [1:0]  cls;     // expected class
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 2'd2, 32'h420995bb, 32'ha18e6450, 16'd2794, 16'd1766, 4'd1, 7'd96, 2'd3},
        '{4'hF, 2'd3, 32'hc772c07c, 32'h0a0a0a01, 16'd53, 16'd40001, 4'd2, 7'd96, 2'd3},
        '{4'hF, 2'd1, 32'h18c48a1e, 32'hc0a80001, 16'd7, 16'd9, 4'd3, 7'd64, 2'd2},
        '{4'h3, 2'd2, 32'h26010203, 32'h0a000102, 16'd80, 16'd443, 4'd4, 7'd64, 2'd2},
        '{4'h5, 2'd3, 32'h01020304, 32'h05060708, 16'd1, 16'd2, 4'd5, 7'd0, 2'd0},
        '{4'hE, 2'd2, 32'h01020304, 32'h05060708, 16'd1, 16'd2, 4'd6, 7'd0, 2'd0},
        '{4'hF, 2'd0, 32'hdeadbeef, 32'hcafef00d, 16'd3, 16'd4, 4'd7, 7'd0, 2'd0},
        '{4'h9, 2'd3, 32'hffffffff, 32'h80000001, 16'hffff, 16'h0001, 4'd8, 7'd96, 2'd3},
        '{4'h5, 2'd1, 32'h11111111, 32'h22222222, 16'd0, 16'd0, 4'd9, 7'd0, 2'd0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   ctrl_i = '0;
    logic [639:0] lut_i = '0;
    logic [3:0]   dflt_chan_i = '0;
    logic         start_i = 1'b0;
    logic [1:0]   ptype_i = '0;
    logic [31:0]  src_ip_i = '0, dst_ip_i = '0;
    logic [15:0]  src_port_i = '0, dst_port_i = '0;
    logic         busy_o, done_o, hash_valid_o, drop_o;
    logic [31:0]  hash_o;
    logic [1:0]   hash_class_o;
    logic [3:0]   chan_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rss_steer u0 (
        .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .key_i(KEY), .lut_i(lut_i),
        .dflt_chan_i(dflt_chan_i), .start_i(start_i), .ptype_i(ptype_i),
        .src_ip_i(src_ip_i), .dst_ip_i(dst_ip_i),
        .src_port_i(src_port_i), .dst_port_i(dst_port_i),
        .busy_o(busy_o), .done_o(done_o), .hash_o(hash_o),
        .hash_valid_o(hash_valid_o), .hash_class_o(hash_class_o),
        .chan_o(chan_o), .drop_o(drop_o)
    );

    function automatic logic [31:0] ref_hash(input logic [95:0] d, input int n);
        logic [31:0] h = '0;
        for (int i = 0; i < n; i++)
            if (d[95-i]) h ^= KEY[319-i -: 32];
        return h;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic fill_lut();
        for (int i = 0; i < DEPTH; i++)
            lut_i[i*5 +: 5] = {((i % 7) != 3), 4'((i * 3 + 5) % 16)};
    endtask

    // drive a packet; returns rising edges from sampling edge until done
    task automatic run_pkt(input vec_t v, output int lat);
        @(negedge clk);
        ctrl_i = v.ctrl; ptype_i = v.pt; src_ip_i = v.sip; dst_ip_i = v.dip;
        src_port_i = v.sp; dst_port_i = v.dp; dflt_chan_i = v.dflt;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 400) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input vec_t v, input int lat, input string tag);
        logic [95:0] d;
        logic [31:0] eh;
        logic [4:0]  ent;
        if (v.nbits == 7'd96) d = {v.sip, v.dip, v.sp, v.dp};
        else                  d = {v.sip, v.dip, 32'd0};
        eh = (v.nbits == 0) ? 32'd0 : ref_hash(d, int'(v.nbits));
        ent = lut_i[eh[6:0]*5 +: 5];
        chk({tag, " R9 latency"}, lat, (v.nbits == 0) ? 1 : int'(v.nbits) + 1);
        chk({tag, " R2/R3/R4 hash"}, hash_o, eh);
        chk({tag, " R5 valid"}, hash_valid_o, (v.nbits != 0));
        chk({tag, " R8 class"}, hash_class_o, v.cls);
        if (v.nbits == 0) begin
            chk({tag, " R5 default chan"}, chan_o, v.dflt);
            chk({tag, " R5 no drop"}, drop_o, 1'b0);
        end else begin
            chk({tag, " R6 chan"}, chan_o, ent[4] ? ent[3:0] : v.dflt);
            chk({tag, " R7 drop"}, drop_o, !ent[4]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        logic [31:0] h_keep;
        int extra;
        vec_t a, b;
        fill_lut();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 done", done_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 hash", hash_o, 0);
        chk("R1 valid", hash_valid_o, 0);
        chk("R1 class", hash_class_o, 0);
        chk("R1 chan", chan_o, 0);
        chk("R1 drop", drop_o, 0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            run_pkt(VECS[k], lat);
            check_result(VECS[k], lat, $sformatf("vec%0d", k));
        end

        // R9: results held between strobes
        h_keep = hash_o;
        repeat (6) @(negedge clk);
        chk("R9 hold done low", done_o, 0);
        chk("R9 hold hash", hash_o, h_keep);

        // R7: all entries invalid -> drop with default channel
        lut_i = '0;
        run_pkt(VECS[0], lat);
        check_result(VECS[0], lat, "alldrop");
        chk("R7 drop set", drop_o, 1);
        chk("R7 default chan", chan_o, VECS[0].dflt);
        fill_lut();

        // R10: start while busy is ignored
        a = VECS[0];
        b = VECS[7];
        @(negedge clk);
        ctrl_i = a.ctrl; ptype_i = a.pt; src_ip_i = a.sip; dst_ip_i = a.dip;
        src_port_i = a.sp; dst_port_i = a.dp; dflt_chan_i = a.dflt;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        ctrl_i = b.ctrl; ptype_i = b.pt; src_ip_i = b.sip; dst_ip_i = b.dip;
        src_port_i = b.sp; dst_port_i = b.dp; dflt_chan_i = b.dflt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 11;
        while (!done_o && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        check_result(a, lat, "busy_start");
        extra = 0;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk("R10 no extra done", extra, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule